// File: doc/BRIEF.md
# Dual-Port Interrupt-on-Change Unit

This block watches two 8-bit general-purpose input ports, called A and B, and raises an interrupt for each port when a watched pin changes. Each pin picks its own comparison reference. The reference is either the value the pin had on the previous clock, or a programmed default bit. When a port's interrupt fires, a flag register records which pins caused it, and a capture register latches the port's pin values at that moment. Both registers then stay frozen until software services the port.

Software reads the live port value, the flags and the captures through a simple registered read port. Reading the live value or the capture of a port clears that port's interrupt. Reading the flags does not. The live value passes through a per-pin polarity inversion mask. Each port drives one interrupt output, modelled as a level plus an output enable. An output can be push-pull active-high, push-pull active-low or open-drain. A mirror control ORs the two ports' interrupt conditions so that both outputs follow either port. Pin values arrive already synchronized to `clk`. All configuration arrives on plain input pins, and the surrounding system drives the direction masks to all-inputs after reset.

Top module: `ioc_unit`

## Requirements
- R1: During and after reset no interrupt is pending, flags and captures read 0, and both outputs sit at their inactive level.
- R2: In previous-value mode (compare-select bit 0), a pin whose value differs from its value one clock earlier sets its flag bit and makes the port pending on that clock edge. The first clock after reset never compares against the previous value.
- R3: In default mode (compare-select bit 1), a pin that differs from its default bit sets its flag bit and makes the port pending.
- R4: Only pins whose direction bit is 1 (input) and whose enable bit is 1 can set a flag or make a port pending.
- R5: When a port becomes pending, its capture register takes the port's pin values from that edge. While the port stays pending, the capture register and the flags do not change.
- R6: A read of address 0 or 4 (port A) or of address 1 or 5 (port B) clears that port's pending state and flags. A read of the flag addresses 2 (A) and 3 (B) clears nothing. Clearing takes priority over a new event on the same edge.
- R7: A read of address 0 or 1 returns the port pins XOR the port's inversion mask. Addresses 2 and 3 return the flags, 4 and 5 return the raw capture, and 6 and 7 return 0.
- R8: With mirror low, each output follows its own port's pending state. With mirror high, both outputs follow (pending A OR pending B).
- R9: Output style: with open-drain high, level is 0 and enable equals asserted. Otherwise enable is 1, and the level equals asserted when active-high is 1, or the inverse of asserted when active-high is 0.
- R10: Read data is registered. It reflects the state at the edge that samples `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_a | input | 8 | Synchronized port A pins |
| pin_b | input | 8 | Synchronized port B pins |
| dir_a | input | 8 | Port A direction, 1 = input |
| dir_b | input | 8 | Port B direction, 1 = input |
| ien_a | input | 8 | Port A per-pin interrupt enable |
| ien_b | input | 8 | Port B per-pin interrupt enable |
| cmp_a | input | 8 | Port A compare select, 1 = default value, 0 = previous value |
| cmp_b | input | 8 | Port B compare select |
| dflt_a | input | 8 | Port A default values |
| dflt_b | input | 8 | Port B default values |
| inv_a | input | 8 | Port A read polarity inversion |
| inv_b | input | 8 | Port B read polarity inversion |
| mirror | input | 1 | OR both interrupt conditions onto both outputs |
| od_mode | input | 1 | Open-drain output style |
| act_high | input | 1 | Push-pull polarity, 1 = active-high |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| int_a_lvl | output | 1 | Interrupt A level |
| int_a_oe | output | 1 | Interrupt A output enable |
| int_b_lvl | output | 1 | Interrupt B level |
| int_b_oe | output | 1 | Interrupt B output enable |

## Verification
The assertions assume that the pin inputs are already synchronous to `clk` and that the direction and enable masks are stable around the edge that raises an interrupt. The flag-cause check compares the flags against the masks sampled on that edge. The stimulus drives every input on the falling edge. It changes configuration only while both ports are idle, and it returns pins to their reference values before it clears a port. Because of this, no event fires on a pin that is being reconfigured.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 3;

  // Upper two address bits choose what is read; bit 0 chooses the port.
  typedef enum logic [1:0] {
    KIND_VAL  = 2'd0,
    KIND_FLAG = 2'd1,
    KIND_CAP  = 2'd2,
    KIND_NONE = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/ioc_detect.sv
module ioc_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] ien,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] dflt,
  input  logic         clr,
  output logic         pending,
  output logic [W-1:0] flag,
  output logic [W-1:0] cap
);
  logic [W-1:0] prev_q;
  logic         prev_ok_q;
  logic [W-1:0] miss;

  // Per-pin mismatch against the selected reference.
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic ref_bit;
    logic armed;
    always_comb begin
      ref_bit = cmp[i] ? dflt[i] : prev_q[i];
      armed   = dir[i] & ien[i] & (cmp[i] | prev_ok_q);
      miss[i] = armed & (pin[i] ^ ref_bit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
      pending   <= 1'b0;
      flag      <= '0;
      cap       <= '0;
    end else begin
      prev_q    <= pin;
      prev_ok_q <= 1'b1;
      if (clr) begin
        pending <= 1'b0;
        flag    <= '0;
      end else if (!pending && (|miss)) begin
        pending <= 1'b1;
        flag    <= miss;
        cap     <= pin;
      end
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr) |=> (pending && $stable(cap) && $stable(flag)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!pending && flag == '0));

  p_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> (flag != '0));

  p_allowed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> ((flag & ~$past(dir & ien)) == '0));
endmodule

// File: rtl/ioc_outfmt.sv
module ioc_outfmt (
  input  logic act,
  input  logic od_mode,
  input  logic act_high,
  output logic lvl,
  output logic oe
);
  always_comb begin
    if (od_mode) begin
      lvl = 1'b0;
      oe  = act;
    end else begin
      lvl = act_high ? act : ~act;
      oe  = 1'b1;
    end
  end
endmodule

// File: rtl/ioc_regread.sv
module ioc_regread
  import ioc_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic [1:0][W-1:0] val,
  input  logic [1:0][W-1:0] flag,
  input  logic [1:0][W-1:0] cap,
  output logic [W-1:0]      rd_data,
  output logic [1:0]        clr
);
  rd_kind_e     kind;
  logic         sel;
  logic [W-1:0] mux;

  always_comb begin
    kind = rd_kind_e'(rd_addr[2:1]);
    sel  = rd_addr[0];
    unique case (kind)
      KIND_VAL:  mux = val[sel];
      KIND_FLAG: mux = flag[sel];
      KIND_CAP:  mux = cap[sel];
      default:   mux = '0;
    endcase
  end

  for (genvar p = 0; p < 2; p++) begin : g_clr
    assign clr[p] = rd_en && (sel == p[0]) &&
                    ((kind == KIND_VAL) || (kind == KIND_CAP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mux;
  end

  p_clr_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/ioc_unit.sv
module ioc_unit
  import ioc_pkg::*;
#(
  parameter int W  = PORT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  pin_a,
  input  logic [W-1:0]  pin_b,
  input  logic [W-1:0]  dir_a,
  input  logic [W-1:0]  dir_b,
  input  logic [W-1:0]  ien_a,
  input  logic [W-1:0]  ien_b,
  input  logic [W-1:0]  cmp_a,
  input  logic [W-1:0]  cmp_b,
  input  logic [W-1:0]  dflt_a,
  input  logic [W-1:0]  dflt_b,
  input  logic [W-1:0]  inv_a,
  input  logic [W-1:0]  inv_b,
  input  logic          mirror,
  input  logic          od_mode,
  input  logic          act_high,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          int_a_lvl,
  output logic          int_a_oe,
  output logic          int_b_lvl,
  output logic          int_b_oe
);
  localparam int NP = 2;

  logic [NP-1:0][W-1:0] pin_v, dir_v, ien_v, cmp_v, dflt_v, inv_v;
  logic [NP-1:0][W-1:0] val_v, flag_v, cap_v;
  logic [NP-1:0]        pend, clr, act, lvl, oe;

  assign pin_v  = {pin_b,  pin_a};
  assign dir_v  = {dir_b,  dir_a};
  assign ien_v  = {ien_b,  ien_a};
  assign cmp_v  = {cmp_b,  cmp_a};
  assign dflt_v = {dflt_b, dflt_a};
  assign inv_v  = {inv_b,  inv_a};

  for (genvar p = 0; p < NP; p++) begin : g_port
    ioc_detect #(.W(W)) det_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (pin_v[p]),
      .dir     (dir_v[p]),
      .ien     (ien_v[p]),
      .cmp     (cmp_v[p]),
      .dflt    (dflt_v[p]),
      .clr     (clr[p]),
      .pending (pend[p]),
      .flag    (flag_v[p]),
      .cap     (cap_v[p])
    );

    assign val_v[p] = pin_v[p] ^ inv_v[p];
    assign act[p]   = mirror ? (|pend) : pend[p];

    ioc_outfmt fmt_i (
      .act      (act[p]),
      .od_mode  (od_mode),
      .act_high (act_high),
      .lvl      (lvl[p]),
      .oe       (oe[p])
    );
  end

  ioc_regread #(.W(W), .AW(AW)) rd_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .val     (val_v),
    .flag    (flag_v),
    .cap     (cap_v),
    .rd_data (rd_data),
    .clr     (clr)
  );

  assign int_a_lvl = lvl[0];
  assign int_a_oe  = oe[0];
  assign int_b_lvl = lvl[1];
  assign int_b_oe  = oe[1];

  p_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mirror |-> (int_a_lvl == int_b_lvl && int_a_oe == int_b_oe));

  p_od_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (od_mode && !(|pend)) |-> (!int_a_oe && !int_b_oe));

  p_own_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mirror && !od_mode && act_high) |-> (int_a_lvl == g_port[0].det_i.pending));
endmodule

// File: tb/ioc_unit_tb_top.sv
module ioc_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pin_a = 0, pin_b = 0, dir_a = 8'hFF, dir_b = 8'hFF;
  logic [7:0] ien_a = 0, ien_b = 0, cmp_a = 0, cmp_b = 0;
  logic [7:0] dflt_a = 0, dflt_b = 0, inv_a = 0, inv_b = 0;
  logic mirror = 0, od_mode = 0, act_high = 0, rd_en = 0;
  logic [2:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic int_a_lvl, int_a_oe, int_b_lvl, int_b_oe;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ioc_unit dut_i (.*);

  // mirror, od, act_high, set_a, set_b, pad, expected {a_lvl,a_oe,b_lvl,b_oe}
  localparam logic [15:0] VEC [9] = '{
    16'b0_0_1_1_0_0000000_1101,
    16'b0_0_0_1_0_0000000_0111,
    16'b1_0_1_1_0_0000000_1111,
    16'b1_0_1_0_1_0000000_1111,
    16'b0_0_1_0_1_0000000_0111,
    16'b0_1_0_0_1_0000000_0001,
    16'b1_1_0_1_0_0000000_0101,
    16'b0_0_1_0_0_0000000_0101,
    16'b1_0_0_0_1_0000000_0101
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] outs();
    return {4'b0, int_a_lvl, int_a_oe, int_b_lvl, int_b_oe};
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) step();
    check("R1 outputs in reset", outs(), 8'h0F);
    rst_n = 1'b1;
    step();
    check("R1 outputs after reset", outs(), 8'h0F);
    rd(3'd2); check("R1 flag A", rd_data, 8'h00);
    rd(3'd5); check("R1 capture B", rd_data, 8'h00);

    // R8, R9: table of output style and mirror vectors
    for (int k = 0; k < 9; k++) begin
      step();
      mirror = VEC[k][15]; od_mode = VEC[k][14]; act_high = VEC[k][13];
      ien_a = 8'h01; ien_b = 8'h01; cmp_a = 8'h01; cmp_b = 8'h01;
      step();
      pin_a[0] = VEC[k][12]; pin_b[0] = VEC[k][11];
      step();
      check($sformatf("R8/R9 vector %0d", k), outs(), {4'b0, VEC[k][3:0]});
      pin_a = 0; pin_b = 0;
      rd(3'd4); rd(3'd5);
    end
    step();
    ien_a = 0; ien_b = 0; cmp_a = 0; cmp_b = 0;
    mirror = 0; od_mode = 0; act_high = 1;
    repeat (2) step();
    check("R9 idle active-high", outs(), 8'h05);

    // R2, R5, R6: previous-value mode on port A
    ien_a = 8'hFF;
    repeat (2) step();
    pin_a = 8'h24;
    step();
    check("R2 port A asserted", {7'b0, int_a_lvl}, 8'h01);
    check("R8 port B idle", {7'b0, int_b_lvl}, 8'h00);
    rd(3'd2); check("R2 flag A", rd_data, 8'h24);
    check("R6 flag read keeps pending", {7'b0, int_a_lvl}, 8'h01);
    pin_a = 8'h00;
    step();
    rd(3'd4); check("R5 capture held", rd_data, 8'h24);
    check("R6 capture read clears", {7'b0, int_a_lvl}, 8'h00);
    rd(3'd2); check("R6 flags cleared", rd_data, 8'h00);

    // R4, R7, R10: direction and enable gating, inversion, read hold
    ien_a = 8'h3C; dir_a = 8'h0F; inv_a = 8'h55;
    step();
    pin_a = 8'hFF;
    step();
    rd(3'd2); check("R4 only input+enabled flagged", rd_data, 8'h0C);
    ien_a = 8'h00;
    rd(3'd0); check("R7 inverted value", rd_data, 8'hAA);
    check("R6 value read clears", {7'b0, int_a_lvl}, 8'h00);
    pin_a = 8'h00;
    step();
    check("R10 read data holds", rd_data, 8'hAA);
    check("R4 disabled pins ignored", {7'b0, int_a_lvl}, 8'h00);
    rd(3'd6); check("R7 unused address", rd_data, 8'h00);
    dir_a = 8'hFF; inv_a = 8'h00;

    // R3: default mode on port B
    pin_b = 8'h80;
    step();
    dflt_b = 8'h80; cmp_b = 8'h81; ien_b = 8'h81;
    repeat (2) step();
    check("R3 matching default idle", {7'b0, int_b_lvl}, 8'h00);
    pin_b = 8'h81;
    step();
    check("R3 port B asserted", {6'b0, int_a_lvl, int_b_lvl}, 8'h01);
    rd(3'd3); check("R3 flag B", rd_data, 8'h01);
    pin_b = 8'h80;
    rd(3'd5); check("R5 capture B", rd_data, 8'h81);
    check("R3 cleared", {7'b0, int_b_lvl}, 8'h00);

    // R6: clearing one port leaves the other pending
    ien_a = 8'h01; cmp_a = 8'h01;
    step();
    pin_a = 8'h01; pin_b = 8'h81;
    step();
    check("R6 both pending", {6'b0, int_a_lvl, int_b_lvl}, 8'h03);
    pin_a = 8'h00; pin_b = 8'h80;
    rd(3'd0);
    check("R6 A cleared B kept", {6'b0, int_a_lvl, int_b_lvl}, 8'h01);
    rd(3'd1);
    check("R7 port B value", rd_data, 8'h80);
    check("R6 B cleared", {6'b0, int_a_lvl, int_b_lvl}, 8'h00);

    // R1: reset mid-event clears state
    pin_a = 8'h01;
    step();
    rst_n = 1'b0;
    step();
    check("R1 reset drops pending", {7'b0, int_a_lvl}, 8'h00);
    pin_a = 8'h00; ien_a = 0; ien_b = 0;
    rst_n = 1'b1;
    step();
    rd(3'd4); check("R1 capture after reset", rd_data, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule